// File: doc/BRIEF.md
# Set/Clear Register GPIO Port

This block is a 32-pin general-purpose I/O port on a single-cycle register bus. Each pin has an output latch and a drive-enable bit. Software never writes the latch directly. One register sets the latch bits for every 1 in the write data, and another clears them. A write to either of these registers also turns on the drive of the addressed pins.

There is no plain direction register. To return pins to inputs, software writes ones to a separate drive-release register; reading that same offset returns the current drive-enable bits. Pin levels enter through a two-flop synchroniser and are read back through a pin-state register. That register is gated by per-pin input-enable bits, which software sets by writing to the pin-state offset.

Reads are registered: the data for a read strobe appears on the read data port one cycle later. The pad outputs come straight from the latch flops.

Top module: `gpio_setclr_port`

## Requirements
- R1: While reset is high, and in the cycle after it falls, pad_out, pad_oe and bus_rdata are all 0, and every input-enable bit is 0.
- R2: A write to offset 0x108 sets pad_out bit i for each 1 in bit i of the data; zero bits leave their latch bits unchanged.
- R3: A write to offset 0x10C clears pad_out bit i for each 1 in bit i of the data; zero bits leave their latch bits unchanged.
- R4: A write to 0x108 or 0x10C sets pad_oe bit i for each 1 in bit i of the data, and leaves the other pad_oe bits unchanged.
- R5: A write to offset 0x100 clears pad_oe bit i for each 1 in bit i of the data and leaves the output latch unchanged.
- R6: A read of 0x100 returns the drive-enable bits and a read of 0x108 returns the output latch. The data appears on bus_rdata the cycle after the read strobe and reflects the state before any write in that same cycle.
- R7: A write to 0x110 sets input-enable bit i for each 1 in bit i of the data. A read of 0x110 returns pad_in through a two-flop synchroniser, ANDed with the input-enable bits, so a level held for two clock edges is visible to the next read.
- R8: A pin whose input-enable bit is 0 reads as 0 at offset 0x110, whatever its pad level.
- R9: Reads of unmapped offsets, and of the write-only offset 0x10C, return 0. Writes to unmapped offsets leave pad_out, pad_oe and the input-enable bits unchanged.
- R10: pad_out and pad_oe take their new values in the cycle after the write strobe, and bus_rdata is 0 in any cycle that follows a cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Registered read data |
| pad_out | output | 32 | Output latch to the pads |
| pad_oe | output | 32 | Per-pin drive enable |
| pad_in | input | 32 | Pad levels, asynchronous |

## Verification
The assertions assume that each strobe names a single access. Where write and read strobes fall in the same cycle, a read is taken to see the state from before the write. They also assume that pad_in is asynchronous, so no property ties a pad level to a particular edge. The stimulus drives the bus away from the clock edge and never raises both strobes in one cycle. It holds pad_in steady for at least three edges before it reads the pin-state register, so the synchroniser delay does not make the expected value uncertain.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  localparam logic [11:0] OFS_DRV_REL = 12'h100;  // read: drive enables, write: release
  localparam logic [11:0] OFS_LAT_SET = 12'h108;  // read: latch, write: set + drive
  localparam logic [11:0] OFS_LAT_CLR = 12'h10C;  // write only: clear + drive
  localparam logic [11:0] OFS_PIN_STS = 12'h110;  // read: pins, write: input enable

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DRV_REL,
    SEL_LAT_SET,
    SEL_LAT_CLR,
    SEL_PIN_STS
  } reg_sel_e;
endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
  import gpio_sc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == ADDR_W'(OFS_DRV_REL))      sel = SEL_DRV_REL;
    else if (addr == ADDR_W'(OFS_LAT_SET)) sel = SEL_LAT_SET;
    else if (addr == ADDR_W'(OFS_LAT_CLR)) sel = SEL_LAT_CLR;
    else if (addr == ADDR_W'(OFS_PIN_STS)) sel = SEL_PIN_STS;
    else                                   sel = SEL_NONE;
  end
endmodule

// File: rtl/gpio_sc_pin.sv
module gpio_sc_pin
  import gpio_sc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr,
  input  reg_sel_e sel,
  input  logic     dbit,
  output logic     lat_q,
  output logic     drv_q,
  output logic     ien_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= 1'b0;
      drv_q <= 1'b0;
      ien_q <= 1'b0;
    end else if (wr && dbit) begin
      unique case (sel)
        SEL_DRV_REL: drv_q <= 1'b0;
        SEL_LAT_SET: begin
          lat_q <= 1'b1;
          drv_q <= 1'b1;
        end
        SEL_LAT_CLR: begin
          lat_q <= 1'b0;
          drv_q <= 1'b1;
        end
        SEL_PIN_STS: ien_q <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
  import gpio_sc_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [N_PINS-1:0] bus_rdata,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  input  logic [N_PINS-1:0] pad_in
);
  reg_sel_e          sel;
  logic [N_PINS-1:0] ien;
  logic [N_PINS-1:0] pin_sync;

  gpio_sc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    gpio_sc_pin u_pin (
      .clk   (clk),
      .rst   (rst),
      .wr    (bus_we),
      .sel   (sel),
      .dbit  (bus_wdata[i]),
      .lat_q (pad_out[i]),
      .drv_q (pad_oe[i]),
      .ien_q (ien[i])
    );
  end

  gpio_sc_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_sync)
  );

  always_ff @(posedge clk) begin
    if (rst || !bus_re) begin
      bus_rdata <= '0;
    end else begin
      unique case (sel)
        SEL_DRV_REL: bus_rdata <= pad_oe;
        SEL_LAT_SET: bus_rdata <= pad_out;
        SEL_PIN_STS: bus_rdata <= pin_sync & ien;
        default:     bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_setclr_port_chk.sv
module gpio_setclr_port_chk
  import gpio_sc_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [N_PINS-1:0] bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [N_PINS-1:0] bus_rdata,
  input logic [N_PINS-1:0] pad_out,
  input logic [N_PINS-1:0] pad_oe
);
  logic a_set, a_clr, a_rel, a_pin, a_map;
  assign a_set = bus_addr == ADDR_W'(OFS_LAT_SET);
  assign a_clr = bus_addr == ADDR_W'(OFS_LAT_CLR);
  assign a_rel = bus_addr == ADDR_W'(OFS_DRV_REL);
  assign a_pin = bus_addr == ADDR_W'(OFS_PIN_STS);
  assign a_map = a_set || a_clr || a_rel || a_pin;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (pad_out == '0 && pad_oe == '0 && bus_rdata == '0));

  a_r2_set_bits: assert property (@(posedge clk) disable iff (rst)
    (bus_we && a_set) |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata)));

  a_r3_clear_bits: assert property (@(posedge clk) disable iff (rst)
    (bus_we && a_clr) |=> ((pad_out & $past(bus_wdata)) == '0));

  a_r4_drive_on: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (a_set || a_clr)) |=> ((pad_oe & $past(bus_wdata)) == $past(bus_wdata)));

  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    (bus_we && a_rel) |=> ((pad_oe & $past(bus_wdata)) == '0 && $stable(pad_out)));

  a_r6_read_drive: assert property (@(posedge clk) disable iff (rst)
    (bus_re && a_rel) |=> (bus_rdata == $past(pad_oe)));

  a_r6_read_latch: assert property (@(posedge clk) disable iff (rst)
    (bus_re && a_set) |=> (bus_rdata == $past(pad_out)));

  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !a_map) |=> ($stable(pad_out) && $stable(pad_oe)));

  a_r9_unmapped_read: assert property (@(posedge clk) disable iff (rst)
    (bus_re && (!a_map || a_clr)) |=> (bus_rdata == '0));

  a_r10_idle_read: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> (bus_rdata == '0));
endmodule

bind gpio_setclr_port gpio_setclr_port_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/test_gpio_setclr_port.sv
module test_gpio_setclr_port;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [11:0]   bus_addr = '0;
  logic [NP-1:0] bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [NP-1:0] bus_rdata, pad_out, pad_oe;
  logic [NP-1:0] pad_in = '0;

  logic [NP-1:0] m_out = '0, m_oe = '0, m_ien = '0;
  int n_run = 0, n_fail = 0, cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_setclr_port i_gpio_setclr_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
  );

  task automatic check(input bit ok, input string req, input logic [NP-1:0] act,
                       input logic [NP-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] exp_read(input logic [11:0] a);
    case (a)
      12'h100: return m_oe;
      12'h108: return m_out;
      12'h110: return pad_in & m_ien;
      default: return '0;
    endcase
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [NP-1:0] d);
    case (a)
      12'h100: m_oe = m_oe & ~d;
      12'h108: begin m_out = m_out | d;  m_oe = m_oe | d; end
      12'h10C: begin m_out = m_out & ~d; m_oe = m_oe | d; end
      12'h110: m_ien = m_ien | d;
      default: ;
    endcase
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [NP-1:0] d, input string req);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    model_write(a, d);
    check(pad_out == m_out, req, pad_out, m_out);
    check(pad_oe == m_oe, req, pad_oe, m_oe);
  endtask

  task automatic bus_read(input logic [11:0] a, input string req);
    logic [NP-1:0] e;
    @(negedge clk);
    e = exp_read(a);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    check(bus_rdata == e, req, bus_rdata, e);
  endtask

  task automatic set_pins(input logic [NP-1:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    logic [11:0] unm [6];
    unm = '{12'h000, 12'h104, 12'h114, 12'hFFC, 12'h200, 12'h10E};
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pad_out == '0, "R1 out", pad_out, '0);
    check(pad_oe == '0, "R1 oe", pad_oe, '0);
    check(bus_rdata == '0, "R1 rdata", bus_rdata, '0);
    rst = 1'b0;
    @(negedge clk);
    check(pad_oe == '0, "R1 oe after", pad_oe, '0);
    set_pins('1);
    bus_read(12'h110, "R1 ien zero / R8");

    // directed corners
    bus_write(12'h108, 32'hA5A5_0001, "R2 set");
    bus_read(12'h108, "R6 latch read");
    bus_read(12'h100, "R4 R6 drive read");
    bus_write(12'h108, 32'h0000_0000, "R2 zero set no change");
    bus_write(12'h10C, 32'h8000_0001, "R3 clear");
    bus_write(12'h10C, 32'h0F00_0000, "R3 R4 clear drives");
    bus_write(12'h100, 32'hFFFF_0000, "R5 release");
    bus_read(12'h100, "R5 read");
    bus_write(12'h110, 32'h0000_FF0F, "R7 enable");
    set_pins(32'h1234_5678);
    bus_read(12'h110, "R7 R8 pins");
    // R7: change pins and read right after two edges
    @(negedge clk); pad_in = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_read(12'h110, "R7 sync depth");
    bus_read(12'h10C, "R9 write-only read");
    bus_write(12'h114, '1, "R9 unmapped write");
    bus_write(12'h0FC, '1, "R9 unmapped write");
    bus_read(12'h114, "R9 unmapped read");
    bus_read(12'h110, "R9 ien untouched");
    // R10: idle cycle gives zero read data
    @(negedge clk);
    check(bus_rdata == '0, "R10 idle rdata", bus_rdata, '0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      logic [NP-1:0] d;
      op = $urandom_range(0, 7);
      d = $urandom();
      case (op)
        0: bus_write(12'h100, d, "R5 rnd");
        1: bus_write(12'h108, d, "R2 R4 rnd");
        2: bus_write(12'h10C, d, "R3 R4 rnd");
        3: bus_write(12'h110, d & $urandom(), "R7 rnd en");
        4: bus_read(($urandom_range(0, 1) != 0) ? 12'h100 : 12'h108, "R6 rnd");
        5: begin set_pins(d); bus_read(12'h110, "R7 R8 rnd"); end
        6: bus_write(unm[$urandom_range(0, 5)], d, "R9 rnd write");
        default: bus_read(unm[$urandom_range(0, 5)], "R9 rnd read");
      endcase
    end
    bus_read(12'h110, "R7 final");
    finish_run();
  end
endmodule